// File: doc/BRIEF.md
# Descriptor-Chain DMA Channel Engine

This block is one DMA channel. It moves a run of equal-width elements between a fixed device address and a memory address that steps forward after each element. The same request/response memory master port carries descriptor fetches, element reads and element writes. Only one request is outstanding at a time. A read is followed by its write before the next element starts.

There are two operating modes. In single-shot mode the engine takes its transfer from four channel registers that software loaded through a simple load port. In chain mode it reads four-word descriptors from memory, starting at the address held in the link channel register. It keeps following the link word of each descriptor until a descriptor marks itself as the last one. A code in each descriptor's link word decides whether finishing it raises a one-cycle done pulse. A malformed descriptor produces a one-cycle error pulse and stops the engine. Selecting the off mode at any time abandons the work in progress.

Top module: `chain_dma_engine`

## Requirements
- R1: After reset the engine is idle (`engState` = 0), no memory request is valid, and `doneIrq` and `errPulse` are low.
- R2: A start is taken only when the engine is idle and `modeSel` is 1 (chain) or 2 (single-shot). A start request while busy, or while `modeSel` is 0 or 3 (off), has no effect.
- R3: The channel registers are loaded through `regLoadSel`: 0 = device address, 1 = memory address, 2 = size word, 3 = link word. In single-shot mode the engine runs exactly one transfer from these registers and then returns to idle, whatever the link code is.
- R4: In chain mode the engine fetches four 32-bit read requests of size code 2. They go to the link address with its low two bits cleared, plus 0, 4, 8 and 12. The words are taken in the order device address, memory address, size word, link word.
- R5: Link word bits [1:0]: bit 0 set means one `doneIrq` pulse of one cycle after the descriptor's elements are done. Bit 1 set in chain mode means the next descriptor is fetched from the link word with bits [1:0] cleared. Codes 0 and 1 end the run and return the engine to idle.
- R6: Size word bits [13:12] select the element width: 3 = 1 byte, 2 = 2 bytes, 0 = 4 bytes. Bits [10:0] hold the element count. `memReqSize` is 0, 1 or 2 for 1, 2 or 4 bytes. The memory address advances by the width after each element, and the device address stays fixed.
- R7: With `dirToDev` = 1, each element is read from the memory address and written to the device address. With `dirToDev` = 0 it is read from the device and written to memory. Data sits right-aligned on the data buses, and the bytes above the element width are written as zero.
- R8: A width code of 1, or a count above 0x3FF for 1- or 2-byte width, or above 0x7FF for 4-byte width, is a descriptor error. The engine raises `errPulse` for one cycle, makes no element access, gives no done pulse, and is idle in that same cycle.
- R9: A count of zero makes no element access. The descriptor still completes and follows its link code.
- R10: When `modeSel` is off while the engine is busy, the engine is idle on the next cycle and drops the work without a done or error pulse.
- R11: `engState` reads 0 when idle, 1 while fetching a descriptor, 2 while waiting for element read data, and 3 while otherwise moving data.
- R12: A request holds its address and kind stable until `memReqReady` accepts it. While waiting for read data no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regLoadEn | input | 1 | Load strobe for a channel register |
| regLoadSel | input | 2 | Channel register select (0 dev, 1 mem, 2 size, 3 link) |
| regLoadData | input | 32 | Value to load |
| modeSel | input | 2 | 0/3 off, 1 chain, 2 single-shot |
| dirToDev | input | 1 | 1 = memory to device, 0 = device to memory; sampled at start |
| startReq | input | 1 | Start request |
| memReqValid | output | 1 | Memory request valid |
| memReqWrite | output | 1 | Request is a write |
| memReqAddr | output | ADDR_W | Request byte address |
| memReqSize | output | 2 | Access size code (0 = 1 B, 1 = 2 B, 2 = 4 B) |
| memReqWdata | output | 32 | Write data, right-aligned |
| memReqReady | input | 1 | Request accepted this cycle |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data, right-aligned |
| doneIrq | output | 1 | One-cycle descriptor-done pulse |
| errPulse | output | 1 | One-cycle descriptor-error pulse |
| engState | output | 2 | Engine state code |

## Verification
The bench goes after the width boundaries first. It runs 1-, 2- and 4-byte elements in both directions, with and without a stalling memory. A design that stepped the address by the wrong amount, or moved the device address, would show wrong data in the device log or in memory. The chain case mixes all three link codes and a link pointer whose low bits are set. A design that skipped the masking, ignored the follow bit or pulsed done on the silent code would fetch from the wrong place or count the wrong number of pulses. Error descriptors (width code 1, counts just past each width's limit) have to end with one error pulse and no element traffic. Zero-length transfers, a second start while busy and an abort by the off mode check that the engine neither restarts, nor hangs, nor leaves a stray pulse behind.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

  // mode select encodings
  localparam logic [1:0] MODE_OFF    = 2'd0;
  localparam logic [1:0] MODE_CHAIN  = 2'd1;
  localparam logic [1:0] MODE_SINGLE = 2'd2;

  // externally visible engine state codes
  localparam logic [1:0] ENG_IDLE = 2'd0;
  localparam logic [1:0] ENG_DESC = 2'd1;
  localparam logic [1:0] ENG_WAIT = 2'd2;
  localparam logic [1:0] ENG_MOVE = 2'd3;

  typedef enum logic [2:0] {
    F_IDLE, F_FREQ, F_FWAIT, F_CHECK, F_RREQ, F_RWAIT, F_WREQ, F_END
  } fsm_e;

  typedef enum logic [1:0] {
    RK_FETCH = 2'd0,
    RK_READ  = 2'd1,
    RK_WRITE = 2'd2
  } req_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      startSingle;
    logic      startChain;
    logic      capWord;
    logic [1:0] wordIdx;
    logic      followLink;
    logic      latchRd;
    logic      stepElem;
    req_kind_e reqKind;
  } dp_ctl_t;

endpackage

// File: rtl/chain_dma_dpath.sv
module chain_dma_dpath
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 11,
  parameter int WCODE_LSB = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic              regLoadEn,
  input  logic [1:0]        regLoadSel,
  input  logic [31:0]       regLoadData,
  input  logic              dirToDev,
  input  logic [31:0]       memRspData,
  output logic              descErr,
  output logic              countZero,
  output logic              lastElem,
  output logic [1:0]        linkCode,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        reqSize,
  output logic [31:0]       reqWdata
);

  localparam int NREG = 4;
  localparam logic [CNT_W-1:0] MAX_WIDE   = '1;
  localparam logic [CNT_W-1:0] MAX_NARROW = {1'b0, {(CNT_W-1){1'b1}}};

  logic [31:0] chanReg [NREG];

  // channel register bank, one register per generate slot
  for (genvar g = 0; g < NREG; g++) begin : g_chan
    logic [31:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (regLoadEn && regLoadSel == 2'(g)) q <= regLoadData;
    end
    assign chanReg[g] = q;
  end

  logic [ADDR_W-1:0] wDev, wMem, fetchBase;
  logic [1:0]        wCode;
  logic [CNT_W-1:0]  remaining;
  logic [31:0]       wLink, rdHold;
  logic              dirQ;

  function automatic logic [31:0] laneMask(input logic [1:0] code);
    case (code)
      2'd3:    laneMask = 32'h0000_00FF;
      2'd2:    laneMask = 32'h0000_FFFF;
      default: laneMask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] stepBytes(input logic [1:0] code);
    case (code)
      2'd3:    stepBytes = ADDR_W'(1);
      2'd2:    stepBytes = ADDR_W'(2);
      default: stepBytes = ADDR_W'(4);
    endcase
  endfunction

  function automatic logic [1:0] sizeCode(input logic [1:0] code);
    case (code)
      2'd3:    sizeCode = 2'd0;
      2'd2:    sizeCode = 2'd1;
      default: sizeCode = 2'd2;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wDev      <= '0;
      wMem      <= '0;
      wCode     <= '0;
      remaining <= '0;
      wLink     <= '0;
      fetchBase <= '0;
      rdHold    <= '0;
      dirQ      <= 1'b0;
    end else begin
      if (ctl.startSingle || ctl.startChain) dirQ <= dirToDev;
      if (ctl.startSingle) begin
        wDev      <= chanReg[0][ADDR_W-1:0];
        wMem      <= chanReg[1][ADDR_W-1:0];
        wCode     <= chanReg[2][WCODE_LSB +: 2];
        remaining <= chanReg[2][CNT_W-1:0];
        wLink     <= chanReg[3];
      end
      if (ctl.startChain) fetchBase <= {chanReg[3][ADDR_W-1:2], 2'b00};
      if (ctl.followLink) fetchBase <= {wLink[ADDR_W-1:2], 2'b00};
      if (ctl.capWord) begin
        case (ctl.wordIdx)
          2'd0: wDev <= memRspData[ADDR_W-1:0];
          2'd1: wMem <= memRspData[ADDR_W-1:0];
          2'd2: begin
            wCode     <= memRspData[WCODE_LSB +: 2];
            remaining <= memRspData[CNT_W-1:0];
          end
          default: wLink <= memRspData;
        endcase
      end
      if (ctl.latchRd) rdHold <= memRspData & laneMask(wCode);
      if (ctl.stepElem) begin
        wMem      <= wMem + stepBytes(wCode);
        remaining <= remaining - 1'b1;
      end
    end
  end

  always_comb begin
    descErr = (wCode == 2'd1) ||
              (remaining > ((wCode == 2'd0) ? MAX_WIDE : MAX_NARROW));
  end

  assign countZero = (remaining == '0);
  assign lastElem  = (remaining == CNT_W'(1));
  assign linkCode  = wLink[1:0];
  assign reqWdata  = rdHold;

  always_comb begin
    case (ctl.reqKind)
      RK_READ:  begin reqAddr = dirQ ? wMem : wDev; reqSize = sizeCode(wCode); end
      RK_WRITE: begin reqAddr = dirQ ? wDev : wMem; reqSize = sizeCode(wCode); end
      default:  begin
        reqAddr = fetchBase + ADDR_W'({ctl.wordIdx, 2'b00});
        reqSize = 2'd2;
      end
    endcase
  end

endmodule

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
  import chain_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       startReq,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       descErr,
  input  logic       countZero,
  input  logic       lastElem,
  input  logic [1:0] linkCode,
  output dp_ctl_t    ctl,
  output logic       memReqValid,
  output logic       memReqWrite,
  output logic       doneIrq,
  output logic       errPulse,
  output logic [1:0] engState
);

  fsm_e       state, nxt;
  logic [1:0] idx, idxNext;
  logic       runChain, chainNext;
  logic       doneNext, errNext;
  logic       modeOff;

  assign modeOff = (modeSel != MODE_CHAIN) && (modeSel != MODE_SINGLE);

  always_comb begin
    nxt         = state;
    idxNext     = idx;
    chainNext   = runChain;
    doneNext    = 1'b0;
    errNext     = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    ctl         = '0;
    ctl.reqKind = RK_FETCH;
    ctl.wordIdx = idx;
    if (modeOff) begin
      nxt = F_IDLE;
    end else begin
      case (state)
        F_IDLE: if (startReq) begin
          if (modeSel == MODE_SINGLE) begin
            ctl.startSingle = 1'b1;
            chainNext       = 1'b0;
            nxt             = F_CHECK;
          end else begin
            ctl.startChain = 1'b1;
            chainNext      = 1'b1;
            idxNext        = 2'd0;
            nxt            = F_FREQ;
          end
        end
        F_FREQ: begin
          memReqValid = 1'b1;
          if (memReqReady) nxt = F_FWAIT;
        end
        F_FWAIT: if (memRspValid) begin
          ctl.capWord = 1'b1;
          if (idx == 2'd3) nxt = F_CHECK;
          else begin
            idxNext = idx + 2'd1;
            nxt     = F_FREQ;
          end
        end
        F_CHECK: begin
          if (descErr) begin
            errNext = 1'b1;
            nxt     = F_IDLE;
          end else if (countZero) nxt = F_END;
          else nxt = F_RREQ;
        end
        F_RREQ: begin
          memReqValid = 1'b1;
          ctl.reqKind = RK_READ;
          if (memReqReady) nxt = F_RWAIT;
        end
        F_RWAIT: if (memRspValid) begin
          ctl.latchRd = 1'b1;
          nxt         = F_WREQ;
        end
        F_WREQ: begin
          memReqValid = 1'b1;
          memReqWrite = 1'b1;
          ctl.reqKind = RK_WRITE;
          if (memReqReady) begin
            ctl.stepElem = 1'b1;
            nxt          = lastElem ? F_END : F_RREQ;
          end
        end
        F_END: begin
          doneNext = linkCode[0];
          if (runChain && linkCode[1]) begin
            ctl.followLink = 1'b1;
            idxNext        = 2'd0;
            nxt            = F_FREQ;
          end else nxt = F_IDLE;
        end
        default: nxt = F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= F_IDLE;
      idx      <= '0;
      runChain <= 1'b0;
      doneIrq  <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      state    <= nxt;
      idx      <= idxNext;
      runChain <= chainNext;
      doneIrq  <= doneNext;
      errPulse <= errNext;
    end
  end

  always_comb begin
    case (state)
      F_IDLE:           engState = ENG_IDLE;
      F_FREQ, F_FWAIT:  engState = ENG_DESC;
      F_RWAIT:          engState = ENG_WAIT;
      default:          engState = ENG_MOVE;
    endcase
  end

endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regLoadEn,
  input  logic [1:0]        regLoadSel,
  input  logic [31:0]       regLoadData,
  input  logic [1:0]        modeSel,
  input  logic              dirToDev,
  input  logic              startReq,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [1:0]        memReqSize,
  output logic [31:0]       memReqWdata,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  output logic              doneIrq,
  output logic              errPulse,
  output logic [1:0]        engState
);

  dp_ctl_t    ctl;
  logic       descErr, countZero, lastElem;
  logic [1:0] linkCode;

  chain_dma_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeSel     (modeSel),
    .startReq    (startReq),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .descErr     (descErr),
    .countZero   (countZero),
    .lastElem    (lastElem),
    .linkCode    (linkCode),
    .ctl         (ctl),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite),
    .doneIrq     (doneIrq),
    .errPulse    (errPulse),
    .engState    (engState)
  );

  chain_dma_dpath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .regLoadEn   (regLoadEn),
    .regLoadSel  (regLoadSel),
    .regLoadData (regLoadData),
    .dirToDev    (dirToDev),
    .memRspData  (memRspData),
    .descErr     (descErr),
    .countZero   (countZero),
    .lastElem    (lastElem),
    .linkCode    (linkCode),
    .reqAddr     (memReqAddr),
    .reqSize     (memReqSize),
    .reqWdata    (memReqWdata)
  );

endmodule

// File: rtl/chain_dma_checker.sv
module chain_dma_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic              startReq,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              doneIrq,
  input logic              errPulse,
  input logic [1:0]        engState
);

  logic modeOn;
  assign modeOn = (modeSel == 2'd1) || (modeSel == 2'd2);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    engState == 2'd0 |-> !memReqValid);

  p_no_spurious_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (engState == 2'd0 && (!startReq || !modeOn)) |=> engState == 2'd0);

  p_done_one_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (engState == 2'd0 && !doneIrq));

  p_err_one_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);

  p_off_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    !modeOn |=> (engState == 2'd0 && !doneIrq && !errPulse));

  p_wait_no_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    engState == 2'd2 |-> !memReqValid);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady && modeOn) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));

endmodule

bind chain_dma_engine chain_dma_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_chain_dma_engine.sv
`timescale 1ns/1ps
module test_chain_dma_engine;

  localparam logic [9:0] DEVA = 10'h3F0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regLoadEn = 1'b0;
  logic [1:0]  regLoadSel = '0;
  logic [31:0] regLoadData = '0;
  logic [1:0]  modeSel = 2'd0;
  logic        dirToDev = 1'b0;
  logic        startReq = 1'b0;
  logic        memReqValid, memReqWrite;
  logic [31:0] memReqAddr, memReqWdata;
  logic [1:0]  memReqSize;
  logic        memReqReady;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        doneIrq, errPulse;
  logic [1:0]  engState;

  always #2.5 clk = ~clk;

  chain_dma_engine i_chain_dma_engine (
    .clk(clk), .rstN(rstN), .regLoadEn(regLoadEn), .regLoadSel(regLoadSel),
    .regLoadData(regLoadData), .modeSel(modeSel), .dirToDev(dirToDev),
    .startReq(startReq), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqSize(memReqSize), .memReqWdata(memReqWdata),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspData(memRspData),
    .doneIrq(doneIrq), .errPulse(errPulse), .engState(engState)
  );

  // ---------------- memory and device model ----------------
  logic [7:0]  mem [0:1023];
  logic [31:0] devLog [0:63];
  int          devRd = 0, devWr = 0, accCnt = 0, doneCnt = 0, errCnt = 0;
  logic [3:0]  saw = '0;
  logic        stallEn = 1'b0;
  int          tick = 0;
  logic        bdEn = 1'b0;
  logic [9:0]  bdAddr = '0;
  logic [31:0] bdData = '0;

  assign memReqReady = !stallEn || tick[0];

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction
  function automatic logic [31:0] maskN(input int n);
    return (n == 1) ? 32'hFF : (n == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [31:0] devVal(input int k);
    return 32'h5A00_0000 ^ (k * 32'h0103_0507);
  endfunction
  function automatic logic [7:0] patt(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  always @(posedge clk) begin
    int          n;
    logic [9:0]  a;
    logic [31:0] r;
    tick        <= tick + 1;
    memRspValid <= 1'b0;
    if (bdEn) for (int b = 0; b < 4; b++) mem[bdAddr + 10'(b)] <= bdData[8*b +: 8];
    if (rstN) begin
      saw[engState] <= 1'b1;
      if (doneIrq)  doneCnt <= doneCnt + 1;
      if (errPulse) errCnt  <= errCnt + 1;
      if (memReqValid && memReqReady) begin
        accCnt <= accCnt + 1;
        n = nbytes(memReqSize);
        a = memReqAddr[9:0];
        if (memReqWrite) begin
          if (a == DEVA) begin
            devLog[devWr[5:0]] <= memReqWdata & maskN(n);
            devWr <= devWr + 1;
          end else
            for (int b = 0; b < n; b++) mem[a + 10'(b)] <= memReqWdata[8*b +: 8];
        end else begin
          memRspValid <= 1'b1;
          if (a == DEVA) begin
            memRspData <= devVal(devRd) & maskN(n);
            devRd <= devRd + 1;
          end else begin
            r = '0;
            for (int b = 0; b < n; b++) r[8*b +: 8] = mem[a + 10'(b)];
            memRspData <= r;
          end
        end
      end
    end
  end

  // ---------------- checking ----------------
  int total = 0, bad = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic backdoor(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); bdEn = 1'b1; bdAddr = a; bdData = d;
    @(negedge clk); bdEn = 1'b0;
  endtask

  task automatic loadReg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); regLoadEn = 1'b1; regLoadSel = sel; regLoadData = d;
    @(negedge clk); regLoadEn = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (engState != 2'd0 && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) check(1'b0, tag, "timeout waiting for idle", 32'(engState), 32'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic setupSingle(input bit dir, input logic [1:0] wc, input logic [10:0] cnt,
                             input logic [9:0] base, input logic [1:0] link);
    loadReg(2'd0, 32'(DEVA));
    loadReg(2'd1, 32'(base));
    loadReg(2'd2, (32'(wc) << 12) | 32'(cnt));
    loadReg(2'd3, 32'(link));
    dirToDev = dir;
    modeSel  = 2'd2;
  endtask

  typedef struct packed {
    logic       dir;
    logic [1:0] wc;
    logic [10:0] cnt;
    logic [9:0] base;
    logic [1:0] link;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 2'd3, 11'd5, 10'h040, 2'd1},
    '{1'b1, 2'd2, 11'd4, 10'h062, 2'd0},
    '{1'b1, 2'd0, 11'd3, 10'h080, 2'd3},
    '{1'b0, 2'd3, 11'd6, 10'h101, 2'd1},
    '{1'b0, 2'd2, 11'd3, 10'h120, 2'd2},
    '{1'b0, 2'd0, 11'd4, 10'h140, 2'd1}
  };

  // expected element k from memory source at base, width w bytes
  function automatic logic [31:0] srcElem(input int base, input int w, input int k);
    logic [31:0] e = '0;
    for (int b = 0; b < w; b++) e[8*b +: 8] = patt(base + k*w + b);
    return e;
  endfunction

  function automatic logic [31:0] memElem(input int base, input int w, input int k);
    logic [31:0] e = '0;
    for (int b = 0; b < w; b++) e[8*b +: 8] = mem[10'(base + k*w + b)];
    return e;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int d0, e0, a0, w0, r0, mism, w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(engState == 2'd0, "R1", "reset state", 32'(engState), 32'd0);
    check(!memReqValid && !doneIrq && !errPulse, "R1", "reset outputs quiet",
          {memReqValid, doneIrq, errPulse}, 32'd0);

    for (int i = 0; i < 1024; i += 4)
      backdoor(10'(i), {patt(i+3), patt(i+2), patt(i+1), patt(i)});

    // ---- table walk: single-shot transfers, second pass with a stalling memory
    for (int pass = 0; pass < 2; pass++) begin
      stallEn = (pass == 1);
      for (int v = 0; v < 6; v++) begin
        setupSingle(VECS[v].dir, VECS[v].wc, VECS[v].cnt, VECS[v].base, VECS[v].link);
        w  = (VECS[v].wc == 2'd3) ? 1 : (VECS[v].wc == 2'd2) ? 2 : 4;
        d0 = doneCnt; e0 = errCnt; a0 = accCnt; w0 = devWr; r0 = devRd;
        pulseStart();
        waitIdle("R3");
        check(doneCnt - d0 == int'(VECS[v].link[0]), "R5", "single-shot done pulses",
              32'(doneCnt - d0), 32'(VECS[v].link[0]));
        check(errCnt == e0, "R3", "no error on legal descriptor", 32'(errCnt - e0), 32'd0);
        check(accCnt - a0 == 2 * int'(VECS[v].cnt), "R3", "element access count",
              32'(accCnt - a0), 32'(2 * VECS[v].cnt));
        mism = 0;
        for (int k = 0; k < int'(VECS[v].cnt); k++) begin
          if (VECS[v].dir) begin
            if (devLog[6'(w0 + k)] !== srcElem(VECS[v].base, w, k)) mism++;
          end else begin
            if (memElem(VECS[v].base, w, k) !== (devVal(r0 + k) & maskN(w))) mism++;
          end
        end
        if (VECS[v].dir)
          check(mism == 0, "R6", "memory-to-device data and address step", 32'(mism), 32'd0);
        else
          check(mism == 0, "R7", "device-to-memory data and address step", 32'(mism), 32'd0);
      end
    end
    stallEn = 1'b0;

    // ---- chain of three descriptors, link register low bits set
    backdoor(10'h200, 32'(DEVA)); backdoor(10'h204, 32'h050);
    backdoor(10'h208, (32'd3 << 12) | 32'd3); backdoor(10'h20C, 32'h210 | 32'd3);
    backdoor(10'h210, 32'(DEVA)); backdoor(10'h214, 32'h070);
    backdoor(10'h218, (32'd2 << 12) | 32'd2); backdoor(10'h21C, 32'h220 | 32'd2);
    backdoor(10'h220, 32'(DEVA)); backdoor(10'h224, 32'h090);
    backdoor(10'h228, 32'd2);               backdoor(10'h22C, 32'd1);
    loadReg(2'd3, 32'h201);
    dirToDev = 1'b1; modeSel = 2'd1;
    d0 = doneCnt; a0 = accCnt; w0 = devWr;
    pulseStart();
    waitIdle("R4");
    check(doneCnt - d0 == 2, "R5", "chain done pulses for codes 3,2,1", 32'(doneCnt - d0), 32'd2);
    check(accCnt - a0 == 26, "R4", "chain fetch plus element accesses", 32'(accCnt - a0), 32'd26);
    mism = 0;
    for (int k = 0; k < 3; k++) if (devLog[6'(w0 + k)] !== srcElem(32'h050, 1, k)) mism++;
    for (int k = 0; k < 2; k++) if (devLog[6'(w0 + 3 + k)] !== srcElem(32'h070, 2, k)) mism++;
    for (int k = 0; k < 2; k++) if (devLog[6'(w0 + 5 + k)] !== srcElem(32'h090, 4, k)) mism++;
    check(mism == 0, "R4", "chain data from fetched descriptors", 32'(mism), 32'd0);
    check(saw[1] && saw[2] && saw[3], "R11", "state codes seen", 32'(saw), 32'hE);

    // ---- errors: width code 1, counts past each width limit
    setupSingle(1'b1, 2'd1, 11'd2, 10'h040, 2'd1);
    d0 = doneCnt; e0 = errCnt; a0 = accCnt;
    pulseStart(); waitIdle("R8");
    check(errCnt - e0 == 1, "R8", "error pulse on width code 1", 32'(errCnt - e0), 32'd1);
    check(accCnt == a0 && doneCnt == d0, "R8", "no traffic or done on error",
          32'(accCnt - a0 + doneCnt - d0), 32'd0);
    setupSingle(1'b1, 2'd3, 11'h400, 10'h040, 2'd1);
    e0 = errCnt; a0 = accCnt;
    pulseStart(); waitIdle("R8");
    check(errCnt - e0 == 1 && accCnt == a0, "R8", "1-byte count 0x400 rejected",
          32'(errCnt - e0), 32'd1);
    backdoor(10'h230, 32'(DEVA)); backdoor(10'h234, 32'h040);
    backdoor(10'h238, 32'h0000_0400 | (32'd2 << 12)); backdoor(10'h23C, 32'd1);
    loadReg(2'd3, 32'h230); modeSel = 2'd1;
    e0 = errCnt; a0 = accCnt; d0 = doneCnt;
    pulseStart(); waitIdle("R8");
    check(errCnt - e0 == 1 && doneCnt == d0, "R8", "2-byte count 0x400 in chain rejected",
          32'(errCnt - e0), 32'd1);
    check(accCnt - a0 == 4, "R8", "only descriptor fetch before error", 32'(accCnt - a0), 32'd4);

    // ---- zero count
    setupSingle(1'b1, 2'd0, 11'd0, 10'h040, 2'd1);
    d0 = doneCnt; a0 = accCnt;
    pulseStart(); waitIdle("R9");
    check(accCnt == a0, "R9", "zero count makes no access", 32'(accCnt - a0), 32'd0);
    check(doneCnt - d0 == 1, "R9", "zero count still completes", 32'(doneCnt - d0), 32'd1);

    // ---- start while busy is ignored
    setupSingle(1'b1, 2'd3, 11'd8, 10'h040, 2'd1);
    d0 = doneCnt; a0 = accCnt;
    pulseStart();
    repeat (4) @(negedge clk);
    pulseStart();
    waitIdle("R2");
    check(doneCnt - d0 == 1 && accCnt - a0 == 16, "R2", "second start while busy ignored",
          32'(accCnt - a0), 32'd16);

    // ---- start while off is ignored
    modeSel = 2'd0;
    a0 = accCnt;
    pulseStart();
    @(negedge clk);
    check(engState == 2'd0 && accCnt == a0, "R2", "start with mode off ignored",
          32'(engState), 32'd0);

    // ---- abort by off mode
    setupSingle(1'b1, 2'd3, 11'd20, 10'h040, 2'd1);
    d0 = doneCnt; e0 = errCnt;
    pulseStart();
    repeat (10) @(negedge clk);
    modeSel = 2'd0;
    @(negedge clk);
    check(engState == 2'd0 && !memReqValid, "R10", "idle one cycle after off",
          32'(engState), 32'd0);
    repeat (3) @(negedge clk);
    check(doneCnt == d0 && errCnt == e0, "R10", "no pulse after abort",
          32'(doneCnt - d0 + errCnt - e0), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule